// File: doc/BRIEF.md
# Interrupt Source Gating Block

This block merges eight parallel-port interrupt requests and two counter outputs into a single host interrupt line. Software programs two write-only byte registers at offsets 0x14 and 0x15 from the board base. The first register holds a per-source request enable for port A and port B of each of four I/O groups. The second register holds a global enable, a counter-interrupt enable and a bit that chooses which counter output feeds the counter interrupt.

The gating has two levels. A source passes only when its own enable is set and the global enable is set. When the second counter is selected, the first counter acts as its prescaler, and only the second counter's output is examined. The host input is edge-sensitive, so every source must stay high until it is serviced. The block adds no pulse shaping. The merged request goes through one register, so the output line cannot glitch.

Top module: `irq_gate_top`

## Requirements
- R1: After reset both control registers hold zero, and `host_irq_o` stays low whatever the request inputs do.
- R2: A write strobe with address 0x14 loads the port-enable register from `wdata_i[7:0]`. A write strobe with address 0x15 loads the global enable from bit 2, the counter enable from bit 1 and the counter select from bit 0. Writes to any other address change neither register.
- R3: Request bit 2g of `port_req_i` is port A of group g and is enabled by port-enable bit 2g. Request bit 2g+1 is port B of group g and is enabled by bit 2g+1. For example, bits 4 and 5 belong to group 2.
- R4: A port request with its enable bit clear never raises `host_irq_o`, even when the global enable is set.
- R5: With the global enable (0x15 bit 2) clear, no port or counter source raises `host_irq_o`.
- R6: The counter interrupt requires both the global enable and the counter enable. With select set it follows `ctr_out_i[1]`, and with select clear it follows `ctr_out_i[0]`. The unselected counter is ignored.
- R7: `host_irq_o` is the OR of all gated sources, registered once. It changes at the first clock edge after the gated condition changes, and it stays high for as long as a gated source stays high.
- R8: With `wr_en_i` low, the address and data inputs have no effect on either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe, one cycle |
| addr_i | input | 5 | Byte offset from the board base |
| wdata_i | input | 8 | Write data |
| port_req_i | input | 8 | Port interrupt requests, bit 2g is port A and bit 2g+1 is port B of group g |
| ctr_out_i | input | 2 | Counter outputs, bit 0 is counter 0 and bit 1 is counter 1 |
| host_irq_o | output | 1 | Registered host interrupt request |

## Verification
The registers are write-only, so any corrupted enable bit appears only through `host_irq_o`. It shows as a missing or spurious request one clock edge after a matching source is driven. The bench therefore pairs each programmed register value with request patterns that separate neighbouring bits. These include port A against port B, group 2 against the other groups, and counter 0 against counter 1. A stuck global enable or a broken address decode is caught by a stimulus that should leave the line low.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 8;
  localparam int N_GROUPS  = 4;
  localparam int N_SRC     = 2 * N_GROUPS;
  localparam int N_CTR     = 2;

  localparam logic [ADDR_W-1:0] OFS_PORT_EN = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_GLOBAL  = 5'h15;

  // global register bit positions, decoded by software
  localparam int BIT_CTR_SEL = 0;
  localparam int BIT_CTR_EN  = 1;
  localparam int BIT_MASTER  = 2;

  typedef struct packed {
    logic master;
    logic ctr_en;
    logic ctr_sel;
  } glob_cfg_t;
endpackage

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_gate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [N_SRC-1:0]  port_en_o,
  output glob_cfg_t         cfg_o
);

  logic wr_port, wr_glob;
  assign wr_port = wr_en_i && (addr_i == OFS_PORT_EN);
  assign wr_glob = wr_en_i && (addr_i == OFS_GLOBAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_en_o <= '0;
      cfg_o     <= '0;
    end else begin
      if (wr_port) port_en_o <= wdata_i[N_SRC-1:0];
      if (wr_glob) begin
        cfg_o.master  <= wdata_i[BIT_MASTER];
        cfg_o.ctr_en  <= wdata_i[BIT_CTR_EN];
        cfg_o.ctr_sel <= wdata_i[BIT_CTR_SEL];
      end
    end
  end

  a_r2_port_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_PORT_EN) |=> (port_en_o == $past(wdata_i[N_SRC-1:0])));
  a_r2_glob_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_GLOBAL) |=> (cfg_o.master == $past(wdata_i[BIT_MASTER])));
  a_r8_no_write_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(port_en_o) && $stable(cfg_o)));

endmodule

// File: rtl/irq_src_gate.sv
module irq_src_gate
  import irq_gate_pkg::*;
(
  input  logic [N_SRC-1:0] port_en_i,
  input  logic [N_SRC-1:0] port_req_i,
  output logic             any_o
);

  logic [N_SRC-1:0] gated;

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    assign gated[2*g]   = port_en_i[2*g]   & port_req_i[2*g];   // port A
    assign gated[2*g+1] = port_en_i[2*g+1] & port_req_i[2*g+1]; // port B
  end

  assign any_o = |gated;

endmodule

// File: rtl/irq_ctr_sel.sv
module irq_ctr_sel
  import irq_gate_pkg::*;
(
  input  logic [N_CTR-1:0] ctr_i,
  input  logic             ctr_en_i,
  input  logic             sel_i,
  output logic             ctr_irq_o
);

  // sel: last counter in the cascade, else first
  assign ctr_irq_o = ctr_en_i & (sel_i ? ctr_i[N_CTR-1] : ctr_i[0]);

endmodule

// File: rtl/irq_gate_top.sv
module irq_gate_top
  import irq_gate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_SRC-1:0]  port_req_i,
  input  logic [N_CTR-1:0]  ctr_out_i,
  output logic              host_irq_o
);

  logic [N_SRC-1:0] port_en;
  glob_cfg_t        cfg;
  logic             port_any, ctr_irq, irq_d;

  irq_ctrl_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .port_en_o(port_en),
    .cfg_o    (cfg)
  );

  irq_src_gate u_gate (
    .port_en_i (port_en),
    .port_req_i(port_req_i),
    .any_o     (port_any)
  );

  irq_ctr_sel u_ctr (
    .ctr_i    (ctr_out_i),
    .ctr_en_i (cfg.ctr_en),
    .sel_i    (cfg.ctr_sel),
    .ctr_irq_o(ctr_irq)
  );

  assign irq_d = cfg.master & (port_any | ctr_irq);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) host_irq_o <= 1'b0;
    else         host_irq_o <= irq_d;
  end

  a_r5_master_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg.master |=> !host_irq_o);
  a_r4_port_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.master && |(port_en & port_req_i)) |=> host_irq_o);
  a_r6_ctr1_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.master && cfg.ctr_en && cfg.ctr_sel && ctr_out_i[N_CTR-1]) |=> host_irq_o);
  a_r6_ctr0_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.master && cfg.ctr_en && !cfg.ctr_sel && ctr_out_i[0]) |=> host_irq_o);
  a_r7_no_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|(port_en & port_req_i)) && !ctr_irq) |=> !host_irq_o);

endmodule

// File: tb/irq_gate_top_tb_top.sv
module irq_gate_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] req = '0;
  logic [1:0] ctr = '0;
  logic       irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_gate_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .port_req_i(req), .ctr_out_i(ctr), .host_irq_o(irq)
  );

  // {port_en, global, port_req, ctr, expected irq}
  localparam logic [26:0] VEC [14] = '{
    {8'h01, 8'h04, 8'h01, 2'b00, 1'b1}, // R3 group0 A
    {8'h01, 8'h04, 8'h02, 2'b00, 1'b0}, // R4 group0 B not enabled
    {8'h02, 8'h04, 8'h02, 2'b00, 1'b1}, // R3 group0 B
    {8'h30, 8'h04, 8'h10, 2'b00, 1'b1}, // R3 group2 A
    {8'h30, 8'h00, 8'h30, 2'b00, 1'b0}, // R5
    {8'hFF, 8'h04, 8'h00, 2'b11, 1'b0}, // R6 ctr disabled
    {8'h00, 8'h04, 8'hFF, 2'b00, 1'b0}, // R4
    {8'h00, 8'h06, 8'h00, 2'b01, 1'b1}, // R6 ctr0
    {8'h00, 8'h06, 8'h00, 2'b10, 1'b0}, // R6 ctr1 ignored
    {8'h00, 8'h07, 8'h00, 2'b10, 1'b1}, // R6 ctr1
    {8'h00, 8'h07, 8'h00, 2'b01, 1'b0}, // R6 ctr0 ignored
    {8'h00, 8'h05, 8'h00, 2'b11, 1'b0}, // R6 ctr enable off
    {8'h00, 8'h03, 8'h00, 2'b11, 1'b0}, // R5 ctr
    {8'hC0, 8'h04, 8'h80, 2'b00, 1'b1}  // R3 group3 B
  };

  task automatic check(input logic exp, input string tag);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s: host_irq=%b expected %b", tag, irq, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d, input logic en);
    @(negedge clk);
    wr_en = en; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: done=0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    req = 8'hFF; ctr = 2'b11;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(1'b0, "R1 reset state");

    for (int i = 0; i < 14; i++) begin
      req = '0; ctr = '0;
      wr(5'h14, VEC[i][26:19], 1'b1);
      wr(5'h15, VEC[i][18:11], 1'b1);
      req = VEC[i][10:3]; ctr = VEC[i][2:1];
      @(negedge clk);
      check(VEC[i][0], $sformatf("R3/R4/R5/R6 vector %0d", i));
    end

    // R2: other offsets leave the registers alone
    req = '0; ctr = '0;
    wr(5'h14, 8'h00, 1'b1);
    wr(5'h15, 8'h04, 1'b1);
    wr(5'h13, 8'hFF, 1'b1);
    wr(5'h16, 8'hFF, 1'b1);
    req = 8'hFF; ctr = 2'b11;
    @(negedge clk);
    check(1'b0, "R2 other offset ignored");

    // R8: strobe low
    req = '0; ctr = '0;
    wr(5'h14, 8'hFF, 1'b0);
    req = 8'hFF;
    @(negedge clk);
    check(1'b0, "R8 write without strobe");

    // R2: master bit cleared by write to 0x15
    req = '0;
    wr(5'h14, 8'h01, 1'b1);
    wr(5'h15, 8'h00, 1'b1);
    req = 8'h01;
    @(negedge clk);
    check(1'b0, "R2 global write clears master");

    // R7: one-edge latency on rise and fall
    req = '0;
    wr(5'h15, 8'h04, 1'b1);
    @(negedge clk);
    check(1'b0, "R7 idle before request");
    req = 8'h01;
    #1 check(1'b0, "R7 no combinational path");
    @(negedge clk);
    check(1'b1, "R7 rise after one edge");
    repeat (3) @(negedge clk);
    check(1'b1, "R7 held while source high");
    req = 8'h00;
    #1 check(1'b1, "R7 held until edge");
    @(negedge clk);
    check(1'b0, "R7 fall after one edge");

    // R1: reset clears programmed state
    req = 8'h01;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(1'b0, "R1 reset clears enables");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule